// File: doc/BRIEF.md
# Conversion Magnitude and Running-Sum Watcher

This block sits beside a signed converter and looks at every result the converter delivers on its main channel. It takes the magnitude of each result and compares it against a programmed limit. A flag is raised when the magnitude is larger than the limit. The flag can also be qualified so that it is raised only after a programmed number of back-to-back over-limit results.

Alongside the magnitude check, the block adds every delivered result into a signed running sum that clips at its range. A second flag reports, as a level, whether that running sum is currently above its own programmed limit. Software is expected to decode and pack these outputs elsewhere. The block supplies only the two flags and the running-sum value.

Top module: `adc_thresh_watch`

## Requirements
- R1: On a cycle with `res_vld` high and `thr_en` high, and with `rpt_en` low, `thr_flag` is 1 in the following cycle exactly when the magnitude of `res_data` is strictly greater than `thr_lim`. A magnitude equal to the limit leaves the flag at 0.
- R2: A valid result whose magnitude does not exceed `thr_lim` clears `thr_flag` in the following cycle and sets the consecutive over-limit count to zero.
- R3: While `thr_en` is low, `thr_flag` is 0 from the next cycle on and the consecutive over-limit count is held at zero.
- R4: With `rpt_en` high, `thr_flag` rises only on the valid result that brings the count of consecutive over-limit results up to `rpt_target`. Any in-range result restarts the count.
- R5: The consecutive count saturates at `rpt_target`. Further over-limit results keep `thr_flag` at 1. A `rpt_target` of 0 behaves like an unqualified compare.
- R6: The magnitude of the most negative code (0x8000 at the default 16-bit width) is taken as the largest positive code (0x7FFF). It exceeds a limit of 0x7FFE but does not exceed a limit of 0x7FFF.
- R7: With `acc_en` high and `acc_clr` low, each valid result is added as a signed two's-complement value to `acc_value`. The new sum is visible in the following cycle.
- R8: The running sum clips at the largest and smallest signed value of its width (+524287 and -524288 at the default 20 bits) instead of wrapping.
- R9: `acc_clr` high or `acc_en` low makes `acc_value` zero in the following cycle. A clear takes priority over a simultaneous valid result.
- R10: `acc_flag` in each cycle equals the signed comparison "`acc_value` greater than the `acc_lim` of the previous cycle". It clears as soon as the sum no longer exceeds the limit.
- R11: On cycles without `res_vld`, and with no clear or disable, `thr_flag` and `acc_value` keep their values.
- R12: After reset, `thr_flag`, `acc_flag` and `acc_value` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_vld | input | 1 | Strobe marking a new conversion result |
| res_data | input | RES_W | Signed two's-complement conversion result |
| thr_en | input | 1 | Enables the magnitude comparator |
| thr_lim | input | RES_W | Unsigned magnitude limit |
| rpt_en | input | 1 | Qualifies the flag with the consecutive count |
| rpt_target | input | CNT_W | Number of consecutive over-limit results required |
| acc_en | input | 1 | Enables the running sum |
| acc_clr | input | 1 | Clears the running sum |
| acc_lim | input | ACC_W | Signed limit for the running sum |
| thr_flag | output | 1 | Magnitude limit exceeded |
| acc_flag | output | 1 | Running sum above its limit |
| acc_value | output | ACC_W | Signed running sum |

## Verification
Every result of the block appears one clock after the input that causes it. `thr_flag` and `acc_value` follow a sampled `res_vld` one cycle later. A clear, a disable or a change of `acc_lim` also takes effect on `acc_value` or `acc_flag` one cycle later. The bench updates a behavioural model on the same rising edge the design samples. It drives inputs on the falling edge and compares all three outputs five nanoseconds after each rising edge, so the sample always sees the cycle's settled values. After reset the design holds its internal reset for two more edges. The bench keeps the inputs idle through that window so the model and the design agree.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
  localparam int unsigned DEF_RES_W = 16;
  localparam int unsigned DEF_ACC_W = 20;
  localparam int unsigned DEF_CNT_W = 4;

  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_ZERO = 2'd1,
    ACC_ADD  = 2'd2
  } acc_op_e;
endpackage

// File: rtl/adc_abs_sat.sv
module adc_abs_sat #(
  parameter int unsigned RES_W = adc_cmp_pkg::DEF_RES_W
) (
  input  logic [RES_W-1:0] res,
  output logic [RES_W-1:0] mag
);
  localparam logic [RES_W-1:0] MOST_NEG = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] MAX_POS  = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] ONE      = {{(RES_W-1){1'b0}}, 1'b1};

  // R6: the most negative code folds onto the largest positive code
  always_comb begin
    if (!res[RES_W-1]) begin
      mag = res;
    end else if (res == MOST_NEG) begin
      mag = MAX_POS;
    end else begin
      mag = ~res + ONE;
    end
  end
endmodule

// File: rtl/adc_rpt_qual.sv
module adc_rpt_qual #(
  parameter int unsigned RES_W = adc_cmp_pkg::DEF_RES_W,
  parameter int unsigned CNT_W = adc_cmp_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             vld,
  input  logic [RES_W-1:0] mag,
  input  logic [RES_W-1:0] lim,
  input  logic             rpt_en,
  input  logic [CNT_W-1:0] rpt_target,
  output logic             flag
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             over;
  logic             upd_en;

  assign over   = (mag > lim);
  assign upd_en = clr | vld;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (clr) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (vld) begin
      if (over) begin
        if (cnt_q < rpt_target) begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end else begin
        cnt_d = '0;
      end
      flag_d = over && (!rpt_en || (cnt_d >= rpt_target));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/adc_acc_sat.sv
module adc_acc_sat #(
  parameter int unsigned RES_W = adc_cmp_pkg::DEF_RES_W,
  parameter int unsigned ACC_W = adc_cmp_pkg::DEF_ACC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  adc_cmp_pkg::acc_op_e op,
  input  logic [RES_W-1:0]     res,
  input  logic [ACC_W-1:0]     lim,
  output logic [ACC_W-1:0]     acc,
  output logic                 flag
);
  localparam int unsigned     EXT_W   = ACC_W + 1 - RES_W;
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] sum_clip;
  logic             flag_q, flag_d;
  logic             acc_upd;

  assign sum = {acc_q[ACC_W-1], acc_q} + {{EXT_W{res[RES_W-1]}}, res};

  always_comb begin
    if (sum[ACC_W] != sum[ACC_W-1]) begin
      sum_clip = sum[ACC_W] ? ACC_MIN : ACC_MAX;
    end else begin
      sum_clip = sum[ACC_W-1:0];
    end
  end

  always_comb begin
    case (op)
      adc_cmp_pkg::ACC_ZERO: acc_d = '0;
      adc_cmp_pkg::ACC_ADD:  acc_d = sum_clip;
      default:               acc_d = acc_q;
    endcase
    flag_d = ($signed(acc_d) > $signed(lim));
  end

  assign acc_upd = (op != adc_cmp_pkg::ACC_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_upd) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign acc  = acc_q;
  assign flag = flag_q;
endmodule

// File: rtl/adc_thresh_watch.sv
module adc_thresh_watch #(
  parameter int unsigned RES_W = adc_cmp_pkg::DEF_RES_W,
  parameter int unsigned ACC_W = adc_cmp_pkg::DEF_ACC_W,
  parameter int unsigned CNT_W = adc_cmp_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_vld,
  input  logic [RES_W-1:0] res_data,
  input  logic             thr_en,
  input  logic [RES_W-1:0] thr_lim,
  input  logic             rpt_en,
  input  logic [CNT_W-1:0] rpt_target,
  input  logic             acc_en,
  input  logic             acc_clr,
  input  logic [ACC_W-1:0] acc_lim,
  output logic             thr_flag,
  output logic             acc_flag,
  output logic [ACC_W-1:0] acc_value
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [RES_W-1:0]     mag;
  adc_cmp_pkg::acc_op_e acc_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // R9: clear and disable win over a valid result
  always_comb begin
    if (acc_clr || !acc_en) begin
      acc_op = adc_cmp_pkg::ACC_ZERO;
    end else if (res_vld) begin
      acc_op = adc_cmp_pkg::ACC_ADD;
    end else begin
      acc_op = adc_cmp_pkg::ACC_HOLD;
    end
  end

  adc_abs_sat #(.RES_W(RES_W)) abs_i (
    .res (res_data),
    .mag (mag)
  );

  adc_rpt_qual #(.RES_W(RES_W), .CNT_W(CNT_W)) qual_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (!thr_en),
    .vld        (res_vld),
    .mag        (mag),
    .lim        (thr_lim),
    .rpt_en     (rpt_en),
    .rpt_target (rpt_target),
    .flag       (thr_flag)
  );

  adc_acc_sat #(.RES_W(RES_W), .ACC_W(ACC_W)) acc_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .op    (acc_op),
    .res   (res_data),
    .lim   (acc_lim),
    .acc   (acc_value),
    .flag  (acc_flag)
  );
endmodule

// File: rtl/adc_thresh_watch_chk.sv
module adc_thresh_watch_chk #(
  parameter int unsigned ACC_W = adc_cmp_pkg::DEF_ACC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_vld,
  input logic             thr_en,
  input logic             acc_en,
  input logic             acc_clr,
  input logic [ACC_W-1:0] acc_lim,
  input logic             thr_flag,
  input logic             acc_flag,
  input logic [ACC_W-1:0] acc_value
);
  AST_THR_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_en |=> !thr_flag); // R3

  AST_THR_RISE_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_flag) |-> $past(res_vld)); // R1

  AST_THR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_en && !res_vld) |=> $stable(thr_flag)); // R11

  AST_ACC_ZERO_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr || !acc_en) |=> (acc_value == '0)); // R9

  AST_ACC_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_clr && !res_vld) |=> $stable(acc_value)); // R11

  AST_ACC_FLAG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_flag) |-> ($signed(acc_value) > $signed($past(acc_lim)))); // R10
endmodule

bind adc_thresh_watch adc_thresh_watch_chk #(.ACC_W(ACC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_vld   (res_vld),
  .thr_en    (thr_en),
  .acc_en    (acc_en),
  .acc_clr   (acc_clr),
  .acc_lim   (acc_lim),
  .thr_flag  (thr_flag),
  .acc_flag  (acc_flag),
  .acc_value (acc_value)
);

// File: tb/adc_thresh_watch_tb_top.sv
module adc_thresh_watch_tb_top;
  localparam int RES_W = 16;
  localparam int ACC_W = 20;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             res_vld;
  logic [RES_W-1:0] res_data;
  logic             thr_en;
  logic [RES_W-1:0] thr_lim;
  logic             rpt_en;
  logic [CNT_W-1:0] rpt_target;
  logic             acc_en;
  logic             acc_clr;
  logic [ACC_W-1:0] acc_lim;
  logic             thr_flag;
  logic             acc_flag;
  logic [ACC_W-1:0] acc_value;

  always #10 clk = ~clk;

  adc_thresh_watch #(.RES_W(RES_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_data(res_data),
    .thr_en(thr_en), .thr_lim(thr_lim), .rpt_en(rpt_en), .rpt_target(rpt_target),
    .acc_en(acc_en), .acc_clr(acc_clr), .acc_lim(acc_lim),
    .thr_flag(thr_flag), .acc_flag(acc_flag), .acc_value(acc_value)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  string cur_req = "R12";

  // behavioural reference state
  int     m_cnt;
  bit     m_thr;
  bit     m_accf;
  longint m_acc;
  longint r_v, mag_v, sum_v, lim_v;

  localparam longint ACC_HI = (64'sd1 <<< (ACC_W - 1)) - 1;
  localparam longint ACC_LO = -(64'sd1 <<< (ACC_W - 1));
  localparam longint RES_HI = (64'sd1 <<< (RES_W - 1)) - 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_thr = 0; m_accf = 0; m_acc = 0;
    end else begin
      r_v   = longint'($signed(res_data));
      mag_v = (r_v < 0) ? -r_v : r_v;
      if (mag_v > RES_HI) mag_v = RES_HI;
      if (!thr_en) begin
        m_cnt = 0; m_thr = 0;
      end else if (res_vld) begin
        if (mag_v > longint'(thr_lim)) begin
          if (m_cnt < int'(rpt_target)) m_cnt++;
          m_thr = !rpt_en || (m_cnt >= int'(rpt_target));
        end else begin
          m_cnt = 0; m_thr = 0;
        end
      end
      if (acc_clr || !acc_en) begin
        m_acc = 0;
      end else if (res_vld) begin
        sum_v = m_acc + r_v;
        if (sum_v > ACC_HI) sum_v = ACC_HI;
        if (sum_v < ACC_LO) sum_v = ACC_LO;
        m_acc = sum_v;
      end
      lim_v  = longint'($signed(acc_lim));
      m_accf = (m_acc > lim_v);
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (!done) begin
      chk(cur_req, "thr_flag", longint'(thr_flag), longint'(m_thr));
      chk(cur_req, "acc_flag", longint'(acc_flag), longint'(m_accf));
      chk(cur_req, "acc_value", longint'($signed(acc_value)), m_acc);
    end
  end

  task automatic feed(input int r, input int n);
    @(negedge clk);
    res_vld  = 1'b1;
    res_data = RES_W'(r);
    repeat (n) @(negedge clk);
    res_vld  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; res_vld = 1'b0; res_data = '0; thr_en = 1'b0; thr_lim = '0;
    rpt_en = 1'b0; rpt_target = '0; acc_en = 1'b0; acc_clr = 1'b0; acc_lim = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk("R12", "thr_flag reset", longint'(thr_flag), 0);
    chk("R12", "acc_value reset", longint'(acc_value), 0);

    // R1 strict compare, R2 clearing, R11 hold
    cur_req = "R1"; thr_en = 1'b1; thr_lim = RES_W'(100);
    feed(100, 1);  chk("R1", "equal magnitude", longint'(thr_flag), 0);
    feed(101, 1);  chk("R1", "above limit", longint'(thr_flag), 1);
    cur_req = "R11"; idle(3); chk("R11", "hold", longint'(thr_flag), 1);
    cur_req = "R2"; feed(50, 1); chk("R2", "in range", longint'(thr_flag), 0);
    cur_req = "R1"; feed(-101, 1); chk("R1", "negative above", longint'(thr_flag), 1);

    // R3 disable
    cur_req = "R3"; thr_en = 1'b0; idle(1);
    chk("R3", "disabled", longint'(thr_flag), 0);
    feed(5000, 2); idle(1); thr_en = 1'b1;

    // R6 most negative code
    cur_req = "R6"; thr_lim = RES_W'(32767);
    feed(-32768, 1); chk("R6", "max limit", longint'(thr_flag), 0);
    thr_lim = RES_W'(32766);
    feed(-32768, 1); chk("R6", "max-1 limit", longint'(thr_flag), 1);

    // R4 consecutive qualification, R5 saturation
    cur_req = "R4"; thr_lim = RES_W'(200); rpt_en = 1'b1; rpt_target = CNT_W'(3);
    feed(20, 1);
    feed(300, 2); chk("R4", "two in a row", longint'(thr_flag), 0);
    feed(10, 1);
    feed(-300, 2); chk("R4", "restart two", longint'(thr_flag), 0);
    feed(-300, 1); chk("R4", "third", longint'(thr_flag), 1);
    cur_req = "R5"; feed(400, 4); chk("R5", "saturated", longint'(thr_flag), 1);
    cur_req = "R2"; feed(0, 1); chk("R2", "restart", longint'(thr_flag), 0);
    cur_req = "R5"; rpt_target = '0; feed(250, 1); chk("R5", "target zero", longint'(thr_flag), 1);
    rpt_en = 1'b0;

    // R7 accumulation, R10 level flag
    cur_req = "R7"; acc_en = 1'b1; acc_lim = ACC_W'(500); idle(1);
    feed(1000, 1); chk("R7", "first add", longint'($signed(acc_value)), 1000);
    feed(-300, 1); chk("R7", "second add", longint'($signed(acc_value)), 700);
    cur_req = "R10"; chk("R10", "above", longint'(acc_flag), 1);
    feed(-300, 1); chk("R10", "below", longint'(acc_flag), 0);
    acc_lim = ACC_W'(-1000); idle(1); chk("R10", "limit moved", longint'(acc_flag), 1);
    acc_lim = ACC_W'(400); idle(1); chk("R10", "equal", longint'(acc_flag), 0);

    // R9 clear priority and disable
    cur_req = "R9";
    @(negedge clk); acc_clr = 1'b1; res_vld = 1'b1; res_data = RES_W'(77);
    @(negedge clk); acc_clr = 1'b0; res_vld = 1'b0;
    chk("R9", "clear wins", longint'($signed(acc_value)), 0);
    feed(900, 1); acc_en = 1'b0; idle(1);
    chk("R9", "disable zeroes", longint'($signed(acc_value)), 0);
    acc_en = 1'b1;

    // R8 saturation both ways
    cur_req = "R8"; acc_lim = ACC_W'(0);
    feed(32767, 20); chk("R8", "top clip", longint'($signed(acc_value)), ACC_HI);
    feed(-32768, 40); chk("R8", "bottom clip", longint'($signed(acc_value)), ACC_LO);
    feed(-5, 2); chk("R8", "stay low", longint'($signed(acc_value)), ACC_LO);
    idle(3);

    finish_run();
  end
endmodule